// File: doc/BRIEF.md
# Bus read-cycle handshake controller

This controller sits between a system bus and a peripheral device and runs the read cycle as two interlocked four-phase handshakes. On the bus side it sees a read strobe and answers with a data acknowledge. On the device side it drives a device strobe and watches the device acknowledge. It also drives the enable of the data transceiver that puts the device data onto the bus. The order between the two channels is fixed. The bus strobe starts the device strobe. The device acknowledge lets the transceiver open. The open transceiver raises the bus acknowledge. On the way back down, the transceiver closes first and the device strobe falls afterwards.

Two points in the cycle show the same external levels and still need different outputs. One is while the request is rising. The other is after the bus strobe has dropped. An internal state bit, a registered copy of the bus request, tells these two phases apart. The controller is a clocked state machine. Its inputs are sampled on the rising clock edge and every output comes straight from a flop, so the outputs cannot glitch. A sticky error flag records handshake violations by either partner.

Top module: `rd_handshake_ctrl`

## Requirements
- R1: While rstN is low, devStrobe, xcvrEn, busAck and protoErr are all 0.
- R2: Take the clock edge that first samples busStrobe at 1, with devAck at 0 and the controller idle. devStrobe is still 0 after that edge and goes to 1 after the next edge. xcvrEn and busAck stay at 0.
- R3: xcvrEn goes to 1 after the first edge that samples devAck at 1 while devStrobe is 1 and the request is held. Before that edge it stays at 0.
- R4: busAck goes to 1 one edge after xcvrEn rises and goes to 0 one edge after xcvrEn falls.
- R5: After the edge that first samples busStrobe at 0 in an acknowledged cycle, xcvrEn is still 1. After the second edge xcvrEn is 0 while busAck is still 1. After the third edge busAck and devStrobe are both 0.
- R6: devStrobe is never raised while devAck is sampled at 1. With a request pending, it rises after the first edge that samples devAck at 0.
- R7: protoErr is set after any edge that samples a devAck change that does not match devStrobe: devAck rising while devStrobe is 0, or devAck falling while devStrobe is 1.
- R8: protoErr is set after an edge that samples busStrobe falling while busAck is 0.
- R9: protoErr stays at 1 once set, until reset.
- R10: While the controller waits on the device or on the bus, for any number of cycles, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busStrobe | input | 1 | Bus read strobe, high while a read is requested |
| devAck | input | 1 | Device acknowledge of devStrobe |
| devStrobe | output | 1 | Strobe to the device |
| xcvrEn | output | 1 | Data transceiver enable, high while device data is driven to the bus |
| busAck | output | 1 | Bus acknowledge, high while read data is valid |
| protoErr | output | 1 | Sticky handshake violation flag |

## Verification
Full read cycles run with random device response delays and random bus hold times. This shows that each output change is caused by its own input edge and not by elapsed time, and that outputs hold during every wait. A directed back-to-back case raises the next request while the device still acknowledges the previous one. It separates a correct wait on devAck from an early strobe. Three directed violations are also applied: an unsolicited device acknowledge, a device that withdraws early, and a bus that aborts before acknowledge. Each one must set the sticky flag exactly one edge later, and a clean cycle must never set it.

// File: rtl/rd_hs_pkg.sv
package rd_hs_pkg;

  // Strobes from control to datapath: set or clear one output flop.
  typedef struct packed {
    logic raiseStrobe;
    logic dropStrobe;
    logic raiseXcvr;
    logic dropXcvr;
  } hsStrobes_t;

  // Output levels fed back from datapath to control.
  typedef struct packed {
    logic strobeLvl;
    logic xcvrLvl;
  } hsLevels_t;

endpackage

// File: rtl/rd_hs_control.sv
module rd_hs_control
  import rd_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busStrobe,
  input  logic       devAck,
  input  hsLevels_t  levels,
  output hsStrobes_t strobes
);

  // State-coding bit: registered request, separates rising and falling halves
  logic reqPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqPhase <= 1'b0;
    else       reqPhase <= busStrobe;
  end

  always_comb begin
    strobes = '0;
    // device strobe only after the previous device acknowledge has gone low
    strobes.raiseStrobe = !levels.strobeLvl && reqPhase && !devAck;
    // device strobe released only once the transceiver is closed
    strobes.dropStrobe  = levels.strobeLvl && !levels.xcvrLvl && !reqPhase;
    // transceiver opens on device acknowledge in the rising half
    strobes.raiseXcvr   = !levels.xcvrLvl && levels.strobeLvl && devAck && reqPhase;
    // transceiver closes first in the falling half
    strobes.dropXcvr    = levels.xcvrLvl && !reqPhase;
  end

endmodule

// File: rtl/rd_hs_datapath.sv
module rd_hs_datapath
  import rd_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busStrobe,
  input  logic       devAck,
  input  hsStrobes_t strobes,
  output hsLevels_t  levels,
  output logic       devStrobe,
  output logic       xcvrEn,
  output logic       busAck,
  output logic       protoErr
);

  logic strobeQ, xcvrQ, ackQ, errQ;
  logic prevDevAck, prevBusStrobe;
  logic ackMismatch, earlyRelease;

  assign ackMismatch  = (devAck && !prevDevAck && !strobeQ) ||
                        (!devAck && prevDevAck && strobeQ);
  assign earlyRelease = !busStrobe && prevBusStrobe && !ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ       <= 1'b0;
      xcvrQ         <= 1'b0;
      ackQ          <= 1'b0;
      errQ          <= 1'b0;
      prevDevAck    <= 1'b0;
      prevBusStrobe <= 1'b0;
    end else begin
      if (strobes.raiseStrobe)     strobeQ <= 1'b1;
      else if (strobes.dropStrobe) strobeQ <= 1'b0;
      if (strobes.raiseXcvr)       xcvrQ   <= 1'b1;
      else if (strobes.dropXcvr)   xcvrQ   <= 1'b0;
      ackQ          <= xcvrQ;
      errQ          <= errQ || ackMismatch || earlyRelease;
      prevDevAck    <= devAck;
      prevBusStrobe <= busStrobe;
    end
  end

  assign levels.strobeLvl = strobeQ;
  assign levels.xcvrLvl   = xcvrQ;
  assign devStrobe        = strobeQ;
  assign xcvrEn           = xcvrQ;
  assign busAck           = ackQ;
  assign protoErr         = errQ;

endmodule

// File: rtl/rd_handshake_ctrl.sv
module rd_handshake_ctrl
  import rd_hs_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic busStrobe,
  input  logic devAck,
  output logic devStrobe,
  output logic xcvrEn,
  output logic busAck,
  output logic protoErr
);

  hsStrobes_t strobes;
  hsLevels_t  levels;

  rd_hs_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .busStrobe (busStrobe),
    .devAck    (devAck),
    .levels    (levels),
    .strobes   (strobes)
  );

  rd_hs_datapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .busStrobe (busStrobe),
    .devAck    (devAck),
    .strobes   (strobes),
    .levels    (levels),
    .devStrobe (devStrobe),
    .xcvrEn    (xcvrEn),
    .busAck    (busAck),
    .protoErr  (protoErr)
  );

endmodule

// File: rtl/rd_hs_checker.sv
module rd_hs_checker (
  input logic clk,
  input logic rstN,
  input logic devAck,
  input logic devStrobe,
  input logic xcvrEn,
  input logic busAck,
  input logic protoErr
);

  // R3
  xcvr_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xcvrEn) |-> ($past(devAck) && $past(devStrobe)));

  // R3
  xcvr_inside_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    xcvrEn |-> devStrobe);

  // R4
  ack_after_xcvr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAck) |-> $past(xcvrEn));

  // R5
  xcvr_closes_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xcvrEn) |-> busAck);

  // R5
  strobe_drop_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devStrobe) |-> !xcvrEn);

  // R6
  strobe_waits_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devStrobe) |-> !$past(devAck));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(protoErr) |-> protoErr);

endmodule

bind rd_handshake_ctrl rd_hs_checker i_rd_hs_checker (
  .clk       (clk),
  .rstN      (rstN),
  .devAck    (devAck),
  .devStrobe (devStrobe),
  .xcvrEn    (xcvrEn),
  .busAck    (busAck),
  .protoErr  (protoErr)
);

// File: tb/test_rd_handshake_ctrl.sv
`timescale 1ns/1ps
module test_rd_handshake_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busStrobe = 1'b0;
  logic devAck = 1'b0;
  logic devStrobe, xcvrEn, busAck, protoErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rd_handshake_ctrl i_rd_handshake_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busStrobe (busStrobe),
    .devAck    (devAck),
    .devStrobe (devStrobe),
    .xcvrEn    (xcvrEn),
    .busAck    (busAck),
    .protoErr  (protoErr)
  );

  // Expected output vector {devStrobe, xcvrEn, busAck, protoErr}
  function automatic logic [3:0] outVec(logic s, logic x, logic a, logic e);
    return {s, x, a, e};
  endfunction

  task automatic expectOut(string req, string what, logic [3:0] exp);
    logic [3:0] act;
    act = {devStrobe, xcvrEn, busAck, protoErr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    busStrobe = 1'b0;
    devAck = 1'b0;
    step();
    expectOut("R1", "in reset", outVec(0, 0, 0, 0));
    step();
    rstN = 1'b1;
    step();
  endtask

  // One clean read cycle with given waits; ends with everything idle
  task automatic readCycle(int devDly, int busDly, int relDly);
    busStrobe = 1'b1;
    step(); expectOut("R2", "one edge after request", outVec(0, 0, 0, 0));
    step(); expectOut("R2", "strobe raised", outVec(1, 0, 0, 0));
    for (int i = 0; i < devDly; i++) begin
      step(); expectOut("R10", "waiting device ack", outVec(1, 0, 0, 0));
    end
    devAck = 1'b1;
    step(); expectOut("R3", "xcvr opens on ack", outVec(1, 1, 0, 0));
    step(); expectOut("R4", "bus ack after xcvr", outVec(1, 1, 1, 0));
    for (int i = 0; i < busDly; i++) begin
      step(); expectOut("R10", "waiting bus release", outVec(1, 1, 1, 0));
    end
    busStrobe = 1'b0;
    step(); expectOut("R5", "first edge after release", outVec(1, 1, 1, 0));
    step(); expectOut("R5", "xcvr closed before ack", outVec(1, 0, 1, 0));
    step(); expectOut("R5", "ack and strobe low", outVec(0, 0, 0, 0));
    for (int i = 0; i < relDly; i++) begin
      step(); expectOut("R10", "waiting device release", outVec(0, 0, 0, 0));
    end
    devAck = 1'b0;
    step(); expectOut("R7", "clean cycle no error", outVec(0, 0, 0, 0));
  endtask

  initial begin : watchdog
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    step();
    doReset();
    expectOut("R1", "after reset", outVec(0, 0, 0, 0));

    // directed: zero waits and longer waits
    readCycle(0, 0, 0);
    readCycle(4, 3, 2);

    // random cycles
    for (int n = 0; n < 40; n++) begin
      readCycle(int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                int'($urandom_range(0, 5)));
    end

    // R6: next request while device still acknowledges the previous one
    busStrobe = 1'b1;
    step(); step();
    devAck = 1'b1;
    step(); step();
    busStrobe = 1'b0;
    step(); step(); step();
    expectOut("R5", "first cycle closed", outVec(0, 0, 0, 0));
    busStrobe = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(); expectOut("R6", "strobe held while ack high", outVec(0, 0, 0, 0));
    end
    devAck = 1'b0;
    step(); expectOut("R6", "strobe after ack low", outVec(1, 0, 0, 0));
    devAck = 1'b1;
    step(); expectOut("R3", "second cycle xcvr", outVec(1, 1, 0, 0));
    step();
    busStrobe = 1'b0;
    step(); step(); step();
    devAck = 1'b0;
    step(); expectOut("R7", "back-to-back no error", outVec(0, 0, 0, 0));

    // R7: unsolicited device acknowledge
    devAck = 1'b1;
    step(); expectOut("R7", "ack rise without strobe", outVec(0, 0, 0, 1));
    devAck = 1'b0;
    step(); expectOut("R9", "error held", outVec(0, 0, 0, 1));
    step(); step();
    expectOut("R9", "error still held", outVec(0, 0, 0, 1));
    doReset();
    expectOut("R1", "error cleared by reset", outVec(0, 0, 0, 0));

    // R8: bus aborts before acknowledge
    busStrobe = 1'b1;
    step(); step();
    busStrobe = 1'b0;
    step(); expectOut("R8", "early bus release", outVec(1, 0, 0, 1));
    step(); expectOut("R9", "strobe drops, error held", outVec(0, 0, 0, 1));
    doReset();

    // R7: device withdraws acknowledge while strobe high
    busStrobe = 1'b1;
    step(); step();
    devAck = 1'b1;
    step(); step();
    expectOut("R4", "acked before violation", outVec(1, 1, 1, 0));
    devAck = 1'b0;
    step(); expectOut("R7", "ack fall with strobe high", outVec(1, 1, 1, 1));
    doReset();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule